// File: doc/BRIEF.md
# DRAM refresh and init scheduler

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it stays quiet for a power-up pause. It then runs a fixed burst of warm-up refresh cycles on its own and raises a ready flag. From that point on, an interval timer adds one owed refresh every refresh period. A request tells the neighbouring access sequencer that refresh work is pending.

When the sequencer grants the bus, the block drives one CAS-before-RAS cycle on the strobe lines. The DRAM's internal row counter supplies the row, so no address is driven. The owed count saturates at a limit. At that limit an urgent flag tells the sequencer that it must yield.

All waveform durations are given in clock cycles as parameters. The pause and the refresh period are derived from the clock frequency, and a test-mode parameter shortens both for simulation.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, and for PAUSE cycles after it is released, ras_n and cas_n stay high. During the same time ref_req, ref_urgent and init_done stay low.
- R2: Once the pause has elapsed, exactly INIT_CYCLES refresh cycles run back to back without any grant. Consecutive cycles are separated by one idle clock.
- R3: init_done rises on the clock that follows the last window of the last warm-up cycle. It then stays high until reset.
- R4: A refresh cycle spans T_CSR+T_RASW+T_RP windows. cas_n goes low first, and ras_n follows T_CSR cycles later. cas_n stays low for T_CHR cycles after ras_n falls. ras_n stays low for T_RASW cycles. Both strobes are then high for T_RP cycles of precharge.
- R5: we_n is high at all times, including throughout every refresh cycle.
- R6: After init_done, one refresh becomes owed every REFI clock cycles. ref_req is high exactly while init_done is high and the owed count is non-zero.
- R7: The owed count saturates at OWED_MAX, and further timer expiries are lost. ref_urgent is high exactly while the count equals OWED_MAX.
- R8: A grant starts a cycle only when the block is idle, init_done is high and ref_req is high. A grant at any other time has no effect. Each completed cycle decrements the owed count. If a timer expiry falls on the same clock as a completion, the count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Access sequencer hands the bus to the refresh engine |
| ref_req_o | output | 1 | Refresh work is owed |
| ref_urgent_o | output | 1 | Owed count at its limit; the sequencer must yield |
| init_done_o | output | 1 | Pause and warm-up burst finished |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |

## Verification
The grant input is driven in several patterns, and each one separates a different behaviour.

- **No grant for a long stretch.** The owed count runs into its limit. This shows whether expiries are dropped and whether the urgent flag appears at the right moment.
- **Grant held high.** The saturated backlog drains back to back. After that, single refreshes are served as each one falls due, and expiries coincide with completions.
- **Grant toggling every clock, and sparse one-clock pulses.** These show that a grant is taken only in an idle clock.
- **Reset in the middle of a run, with grant high during the warm-up burst.** This shows that the pause and the warm-up burst ignore the grant.

A behavioural model built from per-window queues predicts every strobe and flag on every clock.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ     = 250,
  parameter int PAUSE_US    = 200,
  parameter int REFI_NS     = 15600,
  parameter bit TEST_MODE   = 1'b0,
  parameter int TEST_PAUSE  = 50,
  parameter int TEST_REFI   = 60,
  parameter int INIT_CYCLES = 8,
  parameter int OWED_MAX    = 8,
  parameter int T_CSR       = 2,
  parameter int T_CHR       = 3,
  parameter int T_RASW      = 15,
  parameter int T_RP        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int PAUSE_CYC = TEST_MODE ? TEST_PAUSE : CLK_MHZ * PAUSE_US;
  localparam int REFI_CYC  = TEST_MODE ? TEST_REFI : (CLK_MHZ * REFI_NS) / 1000;
  localparam int CYC_LEN   = T_CSR + T_RASW + T_RP;
  localparam int PW  = $clog2(PAUSE_CYC + 1);
  localparam int RW  = $clog2(REFI_CYC + 1);
  localparam int OW  = $clog2(OWED_MAX + 1);
  localparam int IW  = $clog2(INIT_CYCLES + 1);
  localparam int PHW = $clog2(CYC_LEN + 1);
  localparam logic [PW-1:0]  PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [RW-1:0]  REFI_LAST  = RW'(REFI_CYC - 1);
  localparam logic [OW-1:0]  OWED_TOP   = OW'(OWED_MAX);
  localparam logic [IW-1:0]  INIT_LAST  = IW'(INIT_CYCLES - 1);
  localparam logic [PHW-1:0] PH_LAST    = PHW'(CYC_LEN - 1);
  localparam logic [PHW-1:0] RAS_BEG    = PHW'(T_CSR);
  localparam logic [PHW-1:0] RAS_END    = PHW'(T_CSR + T_RASW);
  localparam logic [PHW-1:0] CAS_END    = PHW'(T_CSR + T_CHR);

  logic [PW-1:0]  pcnt;
  logic           paused;
  logic [RW-1:0]  tcnt;
  logic [OW-1:0]  owed, owed_nx;
  logic [IW-1:0]  icnt;
  logic           ready;
  logic           busy;
  logic [PHW-1:0] ph;

  wire done  = busy && (ph == PH_LAST);
  wire tick  = ready && (tcnt == REFI_LAST);
  wire dec   = done && ready;
  wire start = !busy && paused && (!ready || (owed != '0 && grant_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      paused <= 1'b0;
    end else if (!paused) begin
      if (pcnt == PAUSE_LAST) paused <= 1'b1;
      else                    pcnt   <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (done) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (busy) begin
      ph   <= ph + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      ph   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt  <= '0;
      ready <= 1'b0;
    end else if (done && !ready) begin
      icnt <= icnt + 1'b1;
      if (icnt == INIT_LAST) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else if (ready) tcnt <= tcnt + 1'b1;
  end

  always_comb begin
    owed_nx = owed;
    if (tick && !dec)      owed_nx = (owed == OWED_TOP) ? owed : owed + 1'b1;
    else if (dec && !tick) owed_nx = owed - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else        owed <= owed_nx;
  end

  assign ras_n_o      = !(busy && ph >= RAS_BEG && ph < RAS_END);
  assign cas_n_o      = !(busy && ph < CAS_END);
  assign we_n_o       = 1'b1;
  assign ref_req_o    = ready && (owed != '0);
  assign ref_urgent_o = (owed == OWED_TOP);
  assign init_done_o  = ready;

  a_r1_silent_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !paused |-> ras_n_o && cas_n_o);
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> !cas_n_o && $past(!cas_n_o));
  a_r4_cas_high_at_ras_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> cas_n_o);
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);
  a_r7_urgent_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent_o && init_done_o) |-> ref_req_o);
  a_r8_req_drops_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req_o) |-> $past(busy));
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int PAUSE = 50;
  localparam int REFI  = 60;
  localparam int INIT  = 8;
  localparam int MAXO  = 8;
  localparam int CSR   = 2;
  localparam int CHR   = 3;
  localparam int RASW  = 15;
  localparam int RP    = 10;
  localparam int LEN   = CSR + RASW + RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic req, urg, rdy, ras_n, cas_n, we_n;

  always #2 clk = ~clk;

  dram_refresh_sched #(.TEST_MODE(1'b1), .TEST_PAUSE(PAUSE), .TEST_REFI(REFI),
    .INIT_CYCLES(INIT), .OWED_MAX(MAXO), .T_CSR(CSR), .T_CHR(CHR),
    .T_RASW(RASW), .T_RP(RP)) dut_i (
    .clk(clk), .rst_n(rst_n), .grant_i(grant), .ref_req_o(req),
    .ref_urgent_o(urg), .init_done_o(rdy), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n));

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic [1:0] wq[$];
  int  ecount = 0, owed_m = 0, icnt_m = 0, tcnt_m = 0;
  bit  busy_m = 0, done_m = 0;
  bit  exp_ras = 1, exp_cas = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete();
      ecount = 0; owed_m = 0; icnt_m = 0; tcnt_m = 0;
      busy_m = 0; done_m = 0; exp_ras = 1; exp_cas = 1;
    end else begin
      bit o_paused, o_done, tick, dec;
      int o_owed;
      logic [1:0] w;
      o_paused = ecount >= PAUSE;
      o_done = done_m;
      o_owed = owed_m;
      tick = o_done && (tcnt_m == REFI - 1);
      if (o_done) tcnt_m = tick ? 0 : tcnt_m + 1;
      dec = 0;
      w = 2'b11;
      if (busy_m) begin
        if (wq.size() == 0) begin
          busy_m = 0;
          if (!o_done) begin
            icnt_m++;
            if (icnt_m == INIT) done_m = 1;
          end else dec = 1;
        end else w = wq.pop_front();
      end else if (o_paused && (!o_done || (o_owed > 0 && grant))) begin
        for (int i = 0; i < LEN; i++)
          wq.push_back({!(i >= CSR && i < CSR + RASW), !(i < CSR + CHR)});
        w = wq.pop_front();
        busy_m = 1;
      end
      exp_ras = w[1];
      exp_cas = w[0];
      owed_m = o_owed + int'(tick) - int'(dec);
      if (owed_m > MAXO) owed_m = MAXO;
      ecount++;
    end
  end

  int done_seen_at = -1;
  bit done_checked = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(ras_n == exp_ras, "R4 ras_n", ras_n, exp_ras);
      check(cas_n == exp_cas, "R4 cas_n", cas_n, exp_cas);
      check(we_n == 1'b1, "R5 we_n", we_n, 1);
      check(rdy == done_m, "R3 init_done", rdy, done_m);
      check(req == (done_m && owed_m > 0), "R6 ref_req", req, int'(done_m && owed_m > 0));
      check(urg == (owed_m == MAXO), "R7 ref_urgent", urg, int'(owed_m == MAXO));
      if (ecount <= PAUSE)
        check(ras_n && cas_n && !rdy && !req, "R1 quiet pause", {ras_n, cas_n, rdy, req}, 4'b1100);
      if (rdy && !done_checked) begin
        done_checked = 1;
        check(ecount == PAUSE + INIT * (LEN + 1), "R2 warm-up length", ecount, PAUSE + INIT * (LEN + 1));
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(1);
    check(ras_n && cas_n && we_n && !req && !urg && !rdy, "R1 reset state",
          {ras_n, cas_n, we_n, req, urg, rdy}, 6'b111000);
    cycles(3);
    rst_n = 1'b1;
    done_checked = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    grant = 1'b0;
    do_reset();
    wait (rdy);
    cycles(700);
    check(urg == 1'b1, "R7 saturated after idle", urg, 1);
    grant = 1'b1;
    cycles(600);
    check(urg == 1'b0, "R8 backlog drained", urg, 0);
    for (int i = 0; i < 400; i++) begin
      grant = ~grant;
      cycles(1);
    end
    for (int i = 0; i < 14; i++) begin
      grant = 1'b1;
      cycles(1);
      grant = 1'b0;
      cycles(36);
    end
    cycles(30);
    grant = 1'b1;
    do_reset();
    cycles(PAUSE + INIT * (LEN + 1) + 200);
    check(rdy == 1'b1, "R2 init after mid-run reset", rdy, 1);
    grant = 1'b0;
    cycles(50);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule